// File: doc/BRIEF.md
# Quadrature Edge-Rate Limiter

This block turns a stream of single-count position requests, each one a step up or a step down, into a pair of quadrature outputs A and B. It keeps a signed count of the quadrature steps still owed to the outputs. It issues at most one step per permitted slot, and the slot is set by a programmable minimum spacing between output edges. When requests arrive faster than the spacing allows, the owed count grows and the outputs fall behind the requested position. When the request rate drops, the outputs issue the owed steps and catch up.

Limiting that lasts too long becomes a fatal fault. The fault is raised when limiting has run for a programmable number of consecutive cycles, or when the owed count exceeds a programmable magnitude. The fault is sticky until reset. It freezes the outputs and closes the request stream. A "limiting active" status is always visible, and it can also be routed to the interrupt line.

Requests use a valid/ready handshake. A request is taken in each cycle where `in_valid` and `in_ready` are both high. `in_ready` is high whenever no fault is latched and falls only when the fault is set. A source that sees `in_ready` low must hold its request or drop it. No request is ever taken while the fault is latched.

Top module: `qdr_edge_limiter`

## Requirements
- R1: Each accepted request with `in_up`=1 adds one to the owed count, and each accepted request with `in_up`=0 subtracts one. A step is issued only while the owed count is nonzero. A forward step is issued when the count is positive and a backward step when it is negative. Once the count reaches zero, the net number of output steps equals the net number of accepted requests.
- R2: Two consecutive changes of {A,B} are at least `gap_cfg`+1 clock cycles apart. With `gap_cfg`=0 the outputs may change in every cycle.
- R3: The output state {A,B} is 00 after reset. Forward steps follow 00, 01, 11, 10, 00. Backward steps follow the reverse order. Each change flips exactly one bit.
- R4: When the spacing timer is idle, a request accepted at clock edge k changes {A,B} at clock edge k+1.
- R5: `limiting` is high while the owed count is nonzero and the spacing timer holds back the next step. After requests stop, every owed step is issued and `limiting` returns low.
- R6: When `persist_cfg` is nonzero and `limiting` stays high for `persist_cfg` consecutive cycles, `fault` is set. A shorter stretch of limiting leaves `fault` low. `fault` stays high until reset.
- R7: When the magnitude of the owed count exceeds `backlog_cfg`, `fault` is set at the next clock edge. A magnitude equal to `backlog_cfg` does not set `fault`.
- R8: While `fault` is high, {A,B} does not change, `in_ready` is low and `irq` is high.
- R9: `irq` equals `fault` OR (`limit_irq_en` AND `limiting`).
- R10: Requests in the opposite direction cancel owed steps that have not yet been issued. Those cancelled steps never appear at the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A position request is offered |
| in_up | input | 1 | Request direction: 1 counts up, 0 counts down |
| in_ready | output | 1 | Request is taken when this and `in_valid` are high |
| gap_cfg | input | GAP_W | Minimum edge spacing minus one, in clock cycles |
| persist_cfg | input | PER_W | Consecutive limiting cycles that set the fault; 0 disables this check |
| backlog_cfg | input | BL_W-2 | Largest owed-step magnitude allowed without a fault |
| limit_irq_en | input | 1 | Routes `limiting` to `irq` |
| quad_a | output | 1 | Quadrature output A |
| quad_b | output | 1 | Quadrature output B |
| limiting | output | 1 | An owed step is being held back by the spacing rule |
| fault | output | 1 | Sticky fatal fault |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench drives inputs and samples outputs on falling edges. With an idle spacing timer, a step appears at the second falling edge after its request is driven: one rising edge accepts the request and the next one issues the step. The bench checks the unchanged state at the first of those falling edges and the new state at the second. A scoreboard queues one expected state for each request taken. Each output change pops the queue and also checks that at least `gap_cfg`+1 falling edges have passed since the previous change. The fault criteria take effect one edge after the condition is met, so the bench samples fault, ready and irq a few cycles after each threshold is crossed. The bench also samples the fault flag while the owed count sits exactly at its limit, where it must still be low.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
  // Output state packed as {A, B}
  typedef logic [1:0] qstate_t;

  function automatic qstate_t qstep_fwd(input qstate_t s);
    case (s)
      2'b00:   return 2'b01;
      2'b01:   return 2'b11;
      2'b11:   return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  function automatic qstate_t qstep_rev(input qstate_t s);
    case (s)
      2'b00:   return 2'b10;
      2'b10:   return 2'b11;
      2'b11:   return 2'b01;
      default: return 2'b00;
    endcase
  endfunction
endpackage

// File: rtl/qdr_pace.sv
// Spacing timer: after each issued step it blocks the next for gap_cfg cycles.
module qdr_pace #(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GAP_W-1:0] gap_cfg,
  input  logic             fire,
  output logic             open
);
  logic [GAP_W-1:0] wait_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              wait_q <= '0;
    else if (fire)           wait_q <= gap_cfg;
    else if (wait_q != '0)   wait_q <= wait_q - 1'b1;
  end

  assign open = (wait_q == '0);

  // R2: a step is only issued into an open slot
  assert_fire_in_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> open);
endmodule

// File: rtl/qdr_backlog.sv
// Signed count of quadrature steps still owed to the outputs.
module qdr_backlog #(
  parameter int BL_W = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   inc,
  input  logic                   dec,
  input  logic                   take_fwd,
  input  logic                   take_rev,
  output logic signed [BL_W-1:0] owed,
  output logic                   pending,
  output logic                   negative
);
  logic signed [BL_W-1:0] owed_q;
  logic signed [2:0]      delta;

  assign delta = $signed({2'b00, inc}) - $signed({2'b00, dec})
               - $signed({2'b00, take_fwd}) + $signed({2'b00, take_rev});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owed_q <= '0;
    else        owed_q <= owed_q + BL_W'(delta);
  end

  assign owed     = owed_q;
  assign pending  = (owed_q != '0);
  assign negative = owed_q[BL_W-1];

  // R1: direction of an issued step matches the sign of the owed count
  assert_fwd_needs_credit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    take_fwd |-> (owed_q > 0));
  assert_rev_needs_debit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    take_rev |-> (owed_q < 0));
endmodule

// File: rtl/qdr_phase.sv
// Two-bit quadrature state stepped in Gray order.
module qdr_phase
  import qdr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step_fwd,
  input  logic step_rev,
  output logic out_a,
  output logic out_b
);
  qstate_t st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        st_q <= 2'b00;
    else if (step_fwd) st_q <= qstep_fwd(st_q);
    else if (step_rev) st_q <= qstep_rev(st_q);
  end

  assign out_a = st_q[1];
  assign out_b = st_q[0];

  // R3: never asked to step both ways at once
  assert_single_direction_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_fwd && step_rev));
endmodule

// File: rtl/qdr_guard.sv
// Fatal-fault detector: persistent limiting or excessive owed count.
module qdr_guard #(
  parameter int BL_W  = 12,
  parameter int PER_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   limiting,
  input  logic signed [BL_W-1:0] owed,
  input  logic [PER_W-1:0]       persist_cfg,
  input  logic [BL_W-3:0]        backlog_cfg,
  output logic                   fault
);
  logic [PER_W-1:0] run_q;
  logic [PER_W:0]   run_nxt;
  logic [BL_W-1:0]  mag;
  logic             too_long;
  logic             too_deep;
  logic             fault_q;

  assign run_nxt  = {1'b0, run_q} + 1'b1;
  assign mag      = owed[BL_W-1] ? BL_W'(-owed) : BL_W'(owed);
  assign too_long = limiting && (persist_cfg != '0) && (run_nxt >= {1'b0, persist_cfg});
  assign too_deep = (mag > {2'b00, backlog_cfg});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      if (!limiting)            run_q <= '0;
      else if (!run_nxt[PER_W]) run_q <= run_nxt[PER_W-1:0];
      if (too_long || too_deep) fault_q <= 1'b1;
    end
  end

  assign fault = fault_q;

  // R6: the fault never clears without reset
  assert_fault_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fault_q) |-> fault_q);
endmodule

// File: rtl/qdr_edge_limiter.sv
module qdr_edge_limiter
  import qdr_pkg::*;
#(
  parameter int GAP_W = 8,
  parameter int BL_W  = 12,
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_up,
  output logic             in_ready,
  input  logic [GAP_W-1:0] gap_cfg,
  input  logic [PER_W-1:0] persist_cfg,
  input  logic [BL_W-3:0]  backlog_cfg,
  input  logic             limit_irq_en,
  output logic             quad_a,
  output logic             quad_b,
  output logic             limiting,
  output logic             fault,
  output logic             irq
);
  localparam int HOLD_W = GAP_W + 1;

  logic                   take;
  logic                   slot_open;
  logic                   pending;
  logic                   negative;
  logic                   step_ok;
  logic                   step_fwd;
  logic                   step_rev;
  logic signed [BL_W-1:0] owed;
  logic                   fault_w;

  assign take     = in_valid && in_ready;
  assign step_ok  = slot_open && pending && !fault_w;
  assign step_fwd = step_ok && !negative;
  assign step_rev = step_ok && negative;

  qdr_pace #(.GAP_W(GAP_W)) u_pace (
    .clk(clk), .rst_n(rst_n), .gap_cfg(gap_cfg),
    .fire(step_ok), .open(slot_open)
  );

  qdr_backlog #(.BL_W(BL_W)) u_backlog (
    .clk(clk), .rst_n(rst_n),
    .inc(take && in_up), .dec(take && !in_up),
    .take_fwd(step_fwd), .take_rev(step_rev),
    .owed(owed), .pending(pending), .negative(negative)
  );

  qdr_phase u_phase (
    .clk(clk), .rst_n(rst_n),
    .step_fwd(step_fwd), .step_rev(step_rev),
    .out_a(quad_a), .out_b(quad_b)
  );

  qdr_guard #(.BL_W(BL_W), .PER_W(PER_W)) u_guard (
    .clk(clk), .rst_n(rst_n), .limiting(limiting), .owed(owed),
    .persist_cfg(persist_cfg), .backlog_cfg(backlog_cfg), .fault(fault_w)
  );

  assign limiting = pending && !slot_open;
  assign fault    = fault_w;
  assign in_ready = !fault_w;
  assign irq      = fault_w || (limit_irq_en && limiting);

  // Edge-spacing monitor at the outputs
  logic [1:0]        ab_prev_q;
  logic [HOLD_W-1:0] hold_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ab_prev_q <= 2'b00;
      hold_q    <= '1;
    end else begin
      ab_prev_q <= {quad_a, quad_b};
      if ({quad_a, quad_b} != ab_prev_q) hold_q <= '0;
      else if (hold_q != '1)             hold_q <= hold_q + 1'b1;
    end
  end

  assert_min_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ({quad_a, quad_b} != ab_prev_q) |-> (hold_q >= {1'b0, gap_cfg}));
  assert_one_bit_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({quad_a, quad_b} ^ ab_prev_q) <= 1);
  assert_frozen_on_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && $past(fault)) |-> $stable({quad_a, quad_b}));
  assert_closed_on_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!in_ready && irq));
endmodule

// File: tb/test_qdr_edge_limiter.sv
module test_qdr_edge_limiter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_up, in_ready;
  logic [7:0]  gap_cfg;
  logic [15:0] persist_cfg;
  logic [9:0]  backlog_cfg;
  logic        limit_irq_en;
  logic        quad_a, quad_b, limiting, fault, irq;

  always #2 clk = ~clk;

  qdr_edge_limiter i_qdr_edge_limiter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_up(in_up), .in_ready(in_ready),
    .gap_cfg(gap_cfg), .persist_cfg(persist_cfg), .backlog_cfg(backlog_cfg),
    .limit_irq_en(limit_irq_en), .quad_a(quad_a), .quad_b(quad_b),
    .limiting(limiting), .fault(fault), .irq(irq)
  );

  int n_checks = 0;
  int n_fails  = 0;
  int exp_pos  = 0;
  logic [1:0] exp_q[$];
  logic sb_on = 1'b1;
  logic mon_on = 1'b0;
  logic [1:0] prev_ab = 2'b00;
  int since = 1000;
  int chg_cnt = 0;
  logic seen_limit = 1'b0;

  function automatic logic [1:0] gray(input int p);
    case (p & 3)
      0: return 2'b00;
      1: return 2'b01;
      2: return 2'b11;
      default: return 2'b10;
    endcase
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on each output change, checks spacing
  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      since++;
      if (limiting) seen_limit = 1'b1;
      if ({quad_a, quad_b} != prev_ab) begin
        chg_cnt++;
        check(since >= int'(gap_cfg) + 1, "R2 spacing", since, int'(gap_cfg) + 1);
        if (sb_on) begin
          if (exp_q.size() == 0) check(1'b0, "R1 unexpected step", int'({quad_a, quad_b}), -1);
          else begin
            logic [1:0] e;
            e = exp_q.pop_front();
            check({quad_a, quad_b} == e, "R3 step value", int'({quad_a, quad_b}), int'(e));
          end
        end
        since = 0;
        prev_ab = {quad_a, quad_b};
      end
    end
  end

  task automatic do_reset();
    mon_on = 1'b0;
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_up = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    exp_q.delete();
    exp_pos = 0;
    prev_ab = 2'b00;
    since = 1000;
    chg_cnt = 0;
    mon_on = 1'b1;
  endtask

  // Driver: offers n requests back to back, pushes one expected state per accepted one
  task automatic send(input logic up, input int n);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1;
      in_up = up;
      if (in_ready) begin
        exp_pos += up ? 1 : -1;
        exp_q.push_back(gray(exp_pos));
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    n_fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic [1:0] held;
    gap_cfg = 8'd0; persist_cfg = 16'd0; backlog_cfg = 10'd1000; limit_irq_en = 1'b0;
    do_reset();

    // Reset state
    check({quad_a, quad_b} == 2'b00, "R3 reset state", int'({quad_a, quad_b}), 0);
    check(in_ready && !fault && !irq && !limiting, "R8 reset flags",
          int'({in_ready, fault, irq, limiting}), 8);

    // Latency of a single request
    in_valid = 1'b1; in_up = 1'b1;
    exp_pos = 1; exp_q.push_back(gray(1));
    @(negedge clk);
    in_valid = 1'b0;
    check({quad_a, quad_b} == 2'b00, "R4 no change one edge after", int'({quad_a, quad_b}), 0);
    @(negedge clk);
    check({quad_a, quad_b} == 2'b01, "R4 change two edges after", int'({quad_a, quad_b}), 1);
    idle(3);

    // Gap 0: back-to-back forward requests, never limiting
    seen_limit = 1'b0;
    send(1'b1, 8);
    idle(5);
    check(!seen_limit, "R2 gap 0 no limiting", int'(seen_limit), 0);
    check(exp_q.size() == 0, "R1 all steps issued", exp_q.size(), 0);
    check({quad_a, quad_b} == gray(exp_pos), "R1 final position", int'({quad_a, quad_b}), int'(gray(exp_pos)));

    // Gap 3: burst outruns the spacing, outputs lag then catch up
    gap_cfg = 8'd3; idle(5);
    seen_limit = 1'b0;
    send(1'b1, 10);
    check(exp_q.size() > 2, "R5 outputs lag", exp_q.size(), 3);
    idle(50);
    check(seen_limit, "R5 limiting seen", int'(seen_limit), 1);
    check(!limiting, "R5 limiting clears", int'(limiting), 0);
    check(exp_q.size() == 0, "R5 caught up", exp_q.size(), 0);

    // Gap 2: backward steps in reverse Gray order
    gap_cfg = 8'd2; idle(5);
    send(1'b0, 6);
    idle(30);
    check(exp_q.size() == 0, "R3 backward drained", exp_q.size(), 0);
    check({quad_a, quad_b} == gray(exp_pos), "R3 backward position", int'({quad_a, quad_b}), int'(gray(exp_pos)));

    // Cancellation: owed steps removed by opposite requests
    gap_cfg = 8'd15; idle(5);
    sb_on = 1'b0; chg_cnt = 0;
    send(1'b1, 3);
    send(1'b0, 2);
    idle(40);
    check(chg_cnt == 1, "R10 one step only", chg_cnt, 1);
    check({quad_a, quad_b} == gray(exp_pos), "R10 net position", int'({quad_a, quad_b}), int'(gray(exp_pos)));
    exp_q.delete(); sb_on = 1'b1;

    // Interrupt routing
    gap_cfg = 8'd10; idle(5);
    send(1'b1, 3);
    check(limiting && !irq, "R9 irq masked", int'({limiting, irq}), 2);
    limit_irq_en = 1'b1;
    #1;
    check(irq, "R9 irq routed", int'(irq), 1);
    idle(40);
    check(!irq && !limiting, "R9 irq drops with limiting", int'({limiting, irq}), 0);
    limit_irq_en = 1'b0;

    // Short limiting below persist threshold: no fault
    gap_cfg = 8'd3; persist_cfg = 16'd10; idle(5);
    send(1'b1, 2);
    idle(20);
    check(!fault, "R6 short limiting no fault", int'(fault), 0);

    // Persistent limiting sets fault, freezes outputs
    gap_cfg = 8'd20; persist_cfg = 16'd5; idle(25);
    send(1'b1, 2);
    idle(10);
    check(fault, "R6 persist fault", int'(fault), 1);
    check(!in_ready && irq, "R8 ready low irq high", int'({in_ready, irq}), 1);
    held = {quad_a, quad_b};
    send(1'b1, 2);
    idle(30);
    check({quad_a, quad_b} == held, "R8 outputs frozen", int'({quad_a, quad_b}), int'(held));
    check(fault, "R6 fault sticky", int'(fault), 1);

    // Owed-count threshold
    gap_cfg = 8'd50; persist_cfg = 16'd0; backlog_cfg = 10'd3;
    do_reset();
    check(!fault, "R6 fault cleared by reset", int'(fault), 0);
    send(1'b1, 4);
    idle(3);
    check(!fault, "R7 at threshold no fault", int'(fault), 0);
    send(1'b1, 1);
    idle(2);
    check(fault, "R7 over threshold fault", int'(fault), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule